// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Static Fallback and Return Stack

This block predicts, in the same cycle as the fetch address is presented, whether the instruction being fetched will redirect the program and where it will go. The fetch stage supplies the address, a two-bit branch kind, the signed displacement and the instruction length. The block answers with a taken flag and a next address. Three sources feed the answer. The main source is a tagged target buffer indexed by the fetch address; each of its entries holds a tag, a stored target and a two-bit saturating confidence counter. When a conditional branch misses the buffer, a static rule on the sign of the displacement decides its direction. A circular stack of return addresses supplies the targets of procedure returns.

The execute stage sends back resolved branches as a program counter, a taken flag and a real target. A resolution trains the buffer entry it hits, or allocates an entry when a taken branch missed. A resolution is merged into a lookup of the same cycle, so the very next fetch already sees it. Depths and widths are parameters. The full-size buffer is 4096 entries. The default here is smaller, and the bench uses 16.

Top module: `brpred_core`

## Requirements
- R1: After reset the target buffer holds no valid entry and the return stack is empty, so no fetch reports a buffer hit and no return is predicted from the stack.
- R2: A conditional branch (kind 2'b01) that misses the buffer and has a negative displacement (sign bit set) is predicted taken, with target PC plus displacement.
- R3: A conditional branch that misses the buffer and has a zero or positive displacement is predicted not taken, with target PC plus length.
- R4: On a buffer hit the direction is bit 1 of the entry's counter, overriding the static rule, and a taken prediction uses the stored target. A not-taken prediction uses PC plus length.
- R5: The counter saturates at 2'b00 and 2'b11. It moves one step toward the outcome on every resolution that hits, and the target is rewritten on a taken hit. A taken resolution that misses allocates the entry at 2'b10 with its target. A not-taken resolution that misses allocates nothing.
- R6: When a resolution and a lookup of the same entry fall in the same cycle, the lookup sees the updated entry.
- R7: A call (kind 2'b10) is always predicted taken, to the stored target on a hit or else to PC plus displacement, and it pushes PC plus length onto the stack.
- R8: A return (kind 2'b11) with a non-empty stack is predicted taken to the top address, raises the stack flag and pops. Returns come back in last-in-first-out order.
- R9: The stack holds 16 entries. A push onto a full stack overwrites the oldest entry, so after 17 calls only the 16 newest return addresses come back, and the 17th return finds the stack empty.
- R10: A return on an empty stack leaves the stack flag low. It follows the buffer hit (counter and stored target) if there is one, and is predicted not taken otherwise.
- R11: A plain instruction (kind 2'b00), or any cycle with fetch valid low, is predicted not taken with target PC plus length. It reports no hit and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | PCW | Address of the fetched instruction |
| fetch_kind | input | 2 | 00 plain, 01 conditional, 10 call, 11 return |
| fetch_disp | input | PCW | Signed branch displacement |
| fetch_len | input | LENW | Instruction length in bytes |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PCW | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PCW | Resolved target address |
| pred_taken | output | 1 | Predicted redirect |
| pred_target | output | PCW | Predicted next fetch address |
| pred_hit | output | 1 | The prediction consulted a valid buffer entry |
| pred_from_stack | output | 1 | The target came from the return stack |

## Verification
The properties assume that fetch_kind is one of the four encodings and that resolutions are reported only for addresses that really are branches. The assumptions are that no second resolution lands on the same buffer slot in the cycle after a taken one, and that reset is held across at least one edge. The directed scenarios keep to these assumptions. Each resolution is spaced a cycle from the next, except in the scenario that deliberately merges a resolution with a lookup. Branch addresses are chosen so that each trained branch owns its own buffer index.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

   typedef enum logic [1:0] {
      BK_PLAIN = 2'b00,
      BK_COND  = 2'b01,
      BK_CALL  = 2'b10,
      BK_RET   = 2'b11
   } br_kind_e;

   localparam logic [1:0] CTR_ALLOC = 2'b10;

   // One saturating step of a two-bit confidence counter.
   function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
      logic [1:0] nxt;
      if (up) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
      else    nxt = (cur == 2'b00) ? cur : cur - 2'b01;
      return nxt;
   endfunction

endpackage

// File: rtl/brpred_static.sv
module brpred_static #(
   parameter int PCW  = 32,
   parameter int LENW = 4
) (
   input  logic [PCW-1:0]  pc,
   input  logic [PCW-1:0]  disp,
   input  logic [LENW-1:0] len,
   output logic            back_taken,
   output logic [PCW-1:0]  jump_pc,
   output logic [PCW-1:0]  fall_pc
);
   generate
      if (LENW >= PCW) begin : g_bad_len
         $error("brpred_static: LENW must be narrower than PCW");
      end
   endgenerate

   // Backward (negative) displacement means a loop: guess taken.
   assign back_taken = disp[PCW-1];
   assign jump_pc    = pc + disp;
   assign fall_pc    = pc + PCW'(len);
endmodule

// File: rtl/brpred_ras.sv
module brpred_ras #(
   parameter int PCW   = 32,
   parameter int DEPTH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic           pop,
   input  logic [PCW-1:0] push_addr,
   output logic [PCW-1:0] top_addr,
   output logic           nonempty
);
   localparam int PW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("brpred_ras: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PW-1:0]   ptr_q;
   logic [CNTW-1:0] cnt_q;
   logic [PW-1:0]   wr_ptr;
   logic            do_pop;
   logic [PCW-1:0]  slot_rd [DEPTH];

   assign wr_ptr   = ptr_q + PW'(1);
   assign nonempty = (cnt_q != '0);
   assign do_pop   = pop && nonempty;

   // Circular pointer: a push on a full stack lands on the oldest slot.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else if (push) begin
         ptr_q <= wr_ptr;
         if (cnt_q != CNTW'(DEPTH)) cnt_q <= cnt_q + CNTW'(1);
      end else if (do_pop) begin
         ptr_q <= ptr_q - PW'(1);
         cnt_q <= cnt_q - CNTW'(1);
      end
   end

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic [PCW-1:0] q;
         always_ff @(posedge clk) begin
            if (push && wr_ptr == PW'(s)) q <= push_addr;
         end
         assign slot_rd[s] = q;
      end
   endgenerate

   assign top_addr = slot_rd[ptr_q];
endmodule

// File: rtl/brpred_btb.sv
module brpred_btb
   import brpred_pkg::*;
#(
   parameter int PCW      = 32,
   parameter int ENTRIES  = 256,
   parameter bit IDX_FOLD = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [PCW-1:0] lk_pc,
   output logic           lk_hit,
   output logic [1:0]     lk_ctr,
   output logic [PCW-1:0] lk_target,
   input  logic           up_valid,
   input  logic [PCW-1:0] up_pc,
   input  logic           up_taken,
   input  logic [PCW-1:0] up_target
);
   localparam int IDXW = $clog2(ENTRIES);
   localparam int TAGW = PCW - IDXW;

   generate
      if (ENTRIES < 2 || (1 << IDXW) != ENTRIES) begin : g_bad_entries
         $error("brpred_btb: ENTRIES must be a power of two, at least 2");
      end
      if (PCW < 2 * IDXW) begin : g_bad_pcw
         $error("brpred_btb: PCW must be at least twice the index width");
      end
   endgenerate

   logic [IDXW-1:0] lk_idx, up_idx;
   logic [TAGW-1:0] lk_tag, up_tag;

   assign lk_tag = lk_pc[PCW-1:IDXW];
   assign up_tag = up_pc[PCW-1:IDXW];

   // Index variant: plain low bits, or low bits folded with the next field.
   generate
      if (IDX_FOLD) begin : g_fold
         assign lk_idx = lk_pc[IDXW-1:0] ^ lk_pc[2*IDXW-1:IDXW];
         assign up_idx = up_pc[IDXW-1:0] ^ up_pc[2*IDXW-1:IDXW];
      end else begin : g_plain
         assign lk_idx = lk_pc[IDXW-1:0];
         assign up_idx = up_pc[IDXW-1:0];
      end
   endgenerate

   logic [ENTRIES-1:0] vld_q;
   logic [TAGW-1:0]    tag_q [ENTRIES];
   logic [PCW-1:0]     tgt_q [ENTRIES];
   logic [1:0]         ctr_q [ENTRIES];

   // Training path.
   logic           up_hit, we;
   logic [1:0]     nx_ctr;
   logic [PCW-1:0] nx_tgt;

   always_comb begin
      up_hit = vld_q[up_idx] && (tag_q[up_idx] == up_tag);
      we     = up_valid && (up_hit || up_taken);
      nx_ctr = up_hit ? ctr_step(ctr_q[up_idx], up_taken) : CTR_ALLOC;
      nx_tgt = up_taken ? up_target : tgt_q[up_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  vld_q         <= '0;
      else if (we) vld_q[up_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) begin
         tag_q[up_idx] <= up_tag;
         tgt_q[up_idx] <= nx_tgt;
         ctr_q[up_idx] <= nx_ctr;
      end
   end

   // Lookup path with write-first bypass of a same-cycle update.
   logic            byp, rd_vld;
   logic [TAGW-1:0] rd_tag;

   always_comb begin
      byp       = we && (up_idx == lk_idx);
      rd_vld    = byp ? 1'b1   : vld_q[lk_idx];
      rd_tag    = byp ? up_tag : tag_q[lk_idx];
      lk_ctr    = byp ? nx_ctr : ctr_q[lk_idx];
      lk_target = byp ? nx_tgt : tgt_q[lk_idx];
      lk_hit    = rd_vld && (rd_tag == lk_tag);
   end
endmodule

// File: rtl/brpred_core.sv
module brpred_core
   import brpred_pkg::*;
#(
   parameter int PCW       = 32,
   parameter int LENW      = 4,
   parameter int ENTRIES   = 256,
   parameter int RAS_DEPTH = 16,
   parameter bit IDX_FOLD  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch_valid,
   input  logic [PCW-1:0]  fetch_pc,
   input  logic [1:0]      fetch_kind,
   input  logic [PCW-1:0]  fetch_disp,
   input  logic [LENW-1:0] fetch_len,
   input  logic            upd_valid,
   input  logic [PCW-1:0]  upd_pc,
   input  logic            upd_taken,
   input  logic [PCW-1:0]  upd_target,
   output logic            pred_taken,
   output logic [PCW-1:0]  pred_target,
   output logic            pred_hit,
   output logic            pred_from_stack
);
   br_kind_e       kind;
   logic           b_hit;
   logic [1:0]     b_ctr;
   logic [PCW-1:0] b_tgt;
   logic           s_back;
   logic [PCW-1:0] s_jump, s_fall;
   logic           r_push, r_pop, r_nonempty;
   logic [PCW-1:0] r_top;

   assign kind = br_kind_e'(fetch_kind);

   brpred_btb #(.PCW(PCW), .ENTRIES(ENTRIES), .IDX_FOLD(IDX_FOLD)) u_btb (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(fetch_pc), .lk_hit(b_hit), .lk_ctr(b_ctr), .lk_target(b_tgt),
      .up_valid(upd_valid), .up_pc(upd_pc), .up_taken(upd_taken),
      .up_target(upd_target)
   );

   brpred_static #(.PCW(PCW), .LENW(LENW)) u_stat (
      .pc(fetch_pc), .disp(fetch_disp), .len(fetch_len),
      .back_taken(s_back), .jump_pc(s_jump), .fall_pc(s_fall)
   );

   brpred_ras #(.PCW(PCW), .DEPTH(RAS_DEPTH)) u_ras (
      .clk(clk), .rst_n(rst_n), .push(r_push), .pop(r_pop),
      .push_addr(s_fall), .top_addr(r_top), .nonempty(r_nonempty)
   );

   always_comb begin
      pred_taken      = 1'b0;
      pred_target     = s_fall;
      pred_from_stack = 1'b0;
      r_push          = 1'b0;
      r_pop           = 1'b0;
      if (fetch_valid) begin
         unique case (kind)
            BK_COND: begin
               pred_taken = b_hit ? b_ctr[1] : s_back;
               if (pred_taken) pred_target = b_hit ? b_tgt : s_jump;
            end
            BK_CALL: begin
               pred_taken  = 1'b1;
               pred_target = b_hit ? b_tgt : s_jump;
               r_push      = 1'b1;
            end
            BK_RET: begin
               if (r_nonempty) begin
                  pred_taken      = 1'b1;
                  pred_target     = r_top;
                  pred_from_stack = 1'b1;
                  r_pop           = 1'b1;
               end else if (b_hit && b_ctr[1]) begin
                  pred_taken  = 1'b1;
                  pred_target = b_tgt;
               end
            end
            default: ;
         endcase
      end
   end

   assign pred_hit = fetch_valid && b_hit;
endmodule

// File: rtl/brpred_sva.sv
module brpred_sva #(
   parameter int PCW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           fetch_valid,
   input logic [PCW-1:0] fetch_pc,
   input logic [1:0]     fetch_kind,
   input logic [PCW-1:0] fetch_disp,
   input logic           upd_valid,
   input logic [PCW-1:0] upd_pc,
   input logic           upd_taken,
   input logic           pred_taken,
   input logic           pred_hit,
   input logic           pred_from_stack
);
   assert_stack_only_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pred_from_stack |-> (fetch_valid && fetch_kind == 2'b11 && pred_taken));

   assert_call_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == 2'b10) |-> pred_taken);

   assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid || fetch_kind == 2'b00) |-> (!pred_taken && !pred_from_stack));

   assert_idle_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> !pred_hit);

   // R2 and R3: on a miss a conditional branch follows its displacement sign.
   assert_static_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == 2'b01 && !pred_hit) |-> (pred_taken == fetch_disp[PCW-1]));

   assert_resolve_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         (!(fetch_valid && fetch_pc == $past(upd_pc) && !upd_valid) || pred_hit));
endmodule

bind brpred_core brpred_sva #(.PCW(PCW)) u_sva (
   .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
   .fetch_kind(fetch_kind), .fetch_disp(fetch_disp), .upd_valid(upd_valid),
   .upd_pc(upd_pc), .upd_taken(upd_taken), .pred_taken(pred_taken),
   .pred_hit(pred_hit), .pred_from_stack(pred_from_stack)
);

// File: tb/sim_brpred_core.sv
`timescale 1ns/1ps
module sim_brpred_core;
   localparam int PCW = 32;
   localparam int LENW = 4;
   localparam time TCK = 8ns;

   localparam logic [1:0] K_PLAIN = 2'b00;
   localparam logic [1:0] K_COND  = 2'b01;
   localparam logic [1:0] K_CALL  = 2'b10;
   localparam logic [1:0] K_RET   = 2'b11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fetch_valid = 1'b0;
   logic [PCW-1:0]  fetch_pc = '0;
   logic [1:0]      fetch_kind = K_PLAIN;
   logic [PCW-1:0]  fetch_disp = '0;
   logic [LENW-1:0] fetch_len = '0;
   logic            upd_valid = 1'b0;
   logic [PCW-1:0]  upd_pc = '0;
   logic            upd_taken = 1'b0;
   logic [PCW-1:0]  upd_target = '0;
   logic            pred_taken, pred_hit, pred_from_stack;
   logic [PCW-1:0]  pred_target;

   int vectors = 0;
   int misses = 0;

   always #(TCK/2) clk = ~clk;

   brpred_core #(.PCW(PCW), .LENW(LENW), .ENTRIES(16), .RAS_DEPTH(16)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .fetch_kind(fetch_kind), .fetch_disp(fetch_disp), .fetch_len(fetch_len),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target), .pred_taken(pred_taken), .pred_target(pred_target),
      .pred_hit(pred_hit), .pred_from_stack(pred_from_stack)
   );

   task automatic compare(input logic et, input logic [PCW-1:0] eg, input logic eh,
                          input logic es, input string req);
      vectors++;
      if (pred_taken !== et || pred_target !== eg || pred_hit !== eh || pred_from_stack !== es) begin
         misses++;
         $display("FAIL %s: taken %0b exp %0b, target %h exp %h, hit %0b exp %0b, stack %0b exp %0b",
                  req, pred_taken, et, pred_target, eg, pred_hit, eh, pred_from_stack, es);
      end
   endtask

   // One fetch, held across exactly one rising edge.
   task automatic probe(input logic [PCW-1:0] pc, input logic [1:0] k, input logic [PCW-1:0] d,
                        input logic [LENW-1:0] l, input logic et, input logic [PCW-1:0] eg,
                        input logic eh, input logic es, input string req);
      @(negedge clk);
      upd_valid = 1'b0;
      fetch_valid = 1'b1; fetch_pc = pc; fetch_kind = k; fetch_disp = d; fetch_len = l;
      #2;
      compare(et, eg, eh, es, req);
   endtask

   task automatic resolve(input logic [PCW-1:0] pc, input logic tk, input logic [PCW-1:0] tg);
      @(negedge clk);
      fetch_valid = 1'b0;
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic t_reset;
      // R1: empty buffer and stack right after reset
      probe(32'h100, K_COND, -32'sd16, 4'd2, 1'b1, 32'hF0, 1'b0, 1'b0, "R1 first branch misses");
      probe(32'h7F0, K_RET, 32'h0, 4'd1, 1'b0, 32'h7F1, 1'b0, 1'b0, "R1 empty stack at reset");
   endtask

   task automatic t_static;
      probe(32'h120, K_COND, 32'h40, 4'd4, 1'b0, 32'h124, 1'b0, 1'b0, "R3 forward miss not taken");
      probe(32'h130, K_COND, -32'sd48, 4'd2, 1'b1, 32'h100, 1'b0, 1'b0, "R2 backward miss taken");
      probe(32'h140, K_PLAIN, 32'h10, 4'd3, 1'b0, 32'h143, 1'b0, 1'b0, "R11 plain not taken");
      // R11: an invalid call slot must not push
      @(negedge clk);
      fetch_valid = 1'b0; fetch_pc = 32'h150; fetch_kind = K_CALL; fetch_disp = 32'h40; fetch_len = 4'd2;
      #2;
      compare(1'b0, 32'h152, 1'b0, 1'b0, "R11 invalid fetch quiet");
      probe(32'h160, K_RET, 32'h0, 4'd1, 1'b0, 32'h161, 1'b0, 1'b0, "R11 invalid call pushed nothing");
   endtask

   task automatic t_train;
      resolve(32'h100, 1'b1, 32'h180);
      probe(32'h100, K_COND, -32'sd16, 4'd2, 1'b1, 32'h180, 1'b1, 1'b0, "R5 allocation weakly taken");
      resolve(32'h100, 1'b0, 32'h0);
      resolve(32'h100, 1'b0, 32'h0);
      probe(32'h100, K_COND, -32'sd16, 4'd2, 1'b0, 32'h102, 1'b1, 1'b0, "R4 hit overrides backward rule");
      resolve(32'h100, 1'b0, 32'h0);
      resolve(32'h100, 1'b1, 32'h180);
      probe(32'h100, K_COND, -32'sd16, 4'd2, 1'b0, 32'h102, 1'b1, 1'b0, "R5 floor then one step up");
      resolve(32'h100, 1'b1, 32'h180);
      resolve(32'h100, 1'b1, 32'h180);
      resolve(32'h100, 1'b1, 32'h180);
      resolve(32'h100, 1'b1, 32'h180);
      resolve(32'h100, 1'b0, 32'h0);
      probe(32'h100, K_COND, 32'h20, 4'd2, 1'b1, 32'h180, 1'b1, 1'b0, "R5 ceiling saturates");
      resolve(32'h503, 1'b0, 32'h600);
      probe(32'h503, K_COND, -32'sd3, 4'd1, 1'b1, 32'h500, 1'b0, 1'b0, "R5 not-taken miss no allocation");
   endtask

   task automatic t_write_first;
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = 32'h205; upd_taken = 1'b1; upd_target = 32'h2A0;
      fetch_valid = 1'b1; fetch_pc = 32'h205; fetch_kind = K_COND; fetch_disp = 32'h20; fetch_len = 4'd2;
      #2;
      compare(1'b1, 32'h2A0, 1'b1, 1'b0, "R6 same-cycle update seen");
      probe(32'h205, K_COND, 32'h20, 4'd2, 1'b1, 32'h2A0, 1'b1, 1'b0, "R6 update retained");
   endtask

   task automatic t_stack;
      probe(32'h300, K_CALL, 32'h100, 4'd3, 1'b1, 32'h400, 1'b0, 1'b0, "R7 call miss target");
      probe(32'h410, K_CALL, 32'h80, 4'd5, 1'b1, 32'h490, 1'b0, 1'b0, "R7 nested call");
      probe(32'h4A0, K_RET, 32'h0, 4'd1, 1'b1, 32'h415, 1'b0, 1'b1, "R8 inner return first");
      probe(32'h4B0, K_RET, 32'h0, 4'd1, 1'b1, 32'h303, 1'b0, 1'b1, "R8 outer return second");
      probe(32'h4C0, K_RET, 32'h0, 4'd1, 1'b0, 32'h4C1, 1'b0, 1'b0, "R10 empty return not taken");
   endtask

   task automatic t_overflow;
      for (int i = 0; i < 17; i++)
         probe(32'h1000 + 32'(i) * 32'h10, K_CALL, 32'h40, 4'd2, 1'b1,
               32'h1040 + 32'(i) * 32'h10, 1'b0, 1'b0, "R7 call pushes");
      for (int i = 16; i >= 1; i--)
         probe(32'h2000, K_RET, 32'h0, 4'd1, 1'b1, 32'h1002 + 32'(i) * 32'h10,
               1'b0, 1'b1, "R9 newest sixteen return");
      probe(32'h2000, K_RET, 32'h0, 4'd1, 1'b0, 32'h2001, 1'b0, 1'b0, "R9 oldest was overwritten");
   endtask

   task automatic t_buffer_fallback;
      resolve(32'h3C7, 1'b1, 32'h900);
      probe(32'h3C7, K_CALL, 32'h10, 4'd2, 1'b1, 32'h900, 1'b1, 1'b0, "R7 call uses stored target");
      probe(32'h3E0, K_RET, 32'h0, 4'd1, 1'b1, 32'h3C9, 1'b0, 1'b1, "R8 return after hit call");
      resolve(32'h40A, 1'b1, 32'h777);
      probe(32'h40A, K_RET, 32'h0, 4'd1, 1'b1, 32'h777, 1'b1, 1'b0, "R10 empty return uses buffer");
   endtask

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_static();
      t_train();
      t_write_first();
      t_stack();
      t_overflow();
      t_buffer_fallback();
      @(negedge clk);
      fetch_valid = 1'b0;
      upd_valid = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin : watchdog
      #(TCK * 20000);
      vectors++;
      misses++;
      $display("FAIL watchdog: run state hung, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule